// File: doc/BRIEF.md
# Fixed-Point Format Requantizer

This block takes one fixed-point number held as a stored integer and re-expresses it in a second fixed-point format. Each format has a total width and a count of integer bits, and is either signed (two's complement, the sign bit counted among the integer bits) or unsigned (plain binary). The real value of a stored integer `s` in a format with `F` fractional bits is `s * 2^-F`, where `F` is total width minus integer bits.

Converting between formats can mean three things. The binary point may move. Surplus fractional bits may need quantizing, either by floor truncation or by round-to-nearest with ties toward plus infinity. The result may also not fit the target range, and then it either wraps to the low output bits or saturates at the format limits. Both formats and both modes are elaboration-time parameters.

A sample enters with a valid strobe and leaves one clock later with its own valid strobe. The block is meant for the boundaries between arithmetic stages whose output must agree bit for bit with a high-level fixed-point software model.

Top module: `fxq_requant`

## Requirements
- R1: A stored input whose discarded fractional bits are all zero maps to the exactly equal output value, with signed formats read as two's complement and unsigned formats read as plain binary.
- R2: In truncate mode, surplus fractional bits are removed by rounding toward minus infinity (floor), for both positive and negative values.
- R3: In round mode, the result is the nearest output step, and an exact tie always goes toward plus infinity, so -0.5 LSB gives 0 and +0.5 LSB gives +1.
- R4: In wrap mode, an out-of-range quantized result keeps only its low W_OUT bits (two's-complement wrap-around).
- R5: When the output has more fractional bits than the input, the stored value is shifted left with zero fill and no rounding takes place.
- R6: In saturate mode, an out-of-range result clamps to the output limits. For a signed output these are stored -2^(W_OUT-1) and 2^(W_OUT-1)-1, which is an asymmetric range. For an unsigned output they are 0 and 2^W_OUT-1.
- R7: A negative input converted to an unsigned output gives 0 in saturate mode and the masked low W_OUT bits in wrap mode.
- R8: Quantization happens before the overflow step, so a carry created by rounding up is then wrapped or saturated.
- R9: valid_o equals valid_i from the previous clock. data_o loads the converted value only in cycles where valid_i was high, and holds its value otherwise.
- R10: While rst is high at a clock edge, valid_o and data_o are cleared to zero on that edge.
- R11: With no mode or signedness parameters given, both formats are signed, quantization is truncate, and overflow is wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | W_IN | Input stored integer |
| valid_o | output | 1 | Output sample strobe, one clock after valid_i |
| data_o | output | W_OUT | Output stored integer |

## Verification
The datapath is combinational up to one output register, so an error in alignment, rounding bias or limit selection shows on data_o in the very next cycle after the affected sample. The values most likely to expose it are the rounding midpoints, the top positive input, and negative inputs headed to an unsigned format. A wrong enable or valid register shows as a valid strobe out of step with the input, or as data changing during an idle cycle, also one cycle after the cause. Every input code of the narrow formats is swept in all four mode pairs and compared against an integer model each clock.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

    typedef enum logic {
        Q_TRUNC = 1'b0,
        Q_ROUND = 1'b1
    } fxq_qmode_e;

    typedef enum logic {
        O_WRAP = 1'b0,
        O_SAT  = 1'b1
    } fxq_omode_e;

    function automatic int fxq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // working width: integer span plus fractional span plus carry and sign margin
    function automatic int fxq_work_width(input int wi, input int ii, input int wo, input int io);
        return fxq_max(ii, io) + fxq_max(wi - ii, wo - io) + 2;
    endfunction

endpackage

// File: rtl/fxq_align.sv
module fxq_align
    import fxq_pkg::*;
#(
    parameter int         W_IN      = 16,
    parameter int         I_IN      = 8,
    parameter bit         IN_SIGNED = 1'b1,
    parameter int         F_OUT     = 4,
    parameter int         IW        = 18,
    parameter fxq_qmode_e Q_MODE    = Q_TRUNC
) (
    input  logic [W_IN-1:0]        data_i,
    output logic signed [IW-1:0]   quant_o
);
    localparam int F_IN = W_IN - I_IN;
    localparam int SH_L = (F_OUT > F_IN) ? (F_OUT - F_IN) : 0;
    localparam int SH_R = (F_IN > F_OUT) ? (F_IN - F_OUT) : 0;

    logic                 fill;
    logic signed [IW-1:0] ext;

    assign fill = IN_SIGNED ? data_i[W_IN-1] : 1'b0;
    assign ext  = {{(IW-W_IN){fill}}, data_i};

    generate
        if (SH_R == 0) begin : g_widen
            assign quant_o = ext <<< SH_L;
        end else if (Q_MODE == Q_ROUND) begin : g_round
            localparam logic signed [IW-1:0] HALF = IW'(1) <<< (SH_R - 1);
            logic signed [IW-1:0] biased;
            logic signed [IW-1:0] resid;
            assign biased  = ext + HALF;
            assign quant_o = biased >>> SH_R;
            always_comb begin
                resid = ext - (quant_o <<< SH_R);
                // R3: remainder lies in [-half, half), so ties resolve upward
                assert_half_up_R3: assert (resid >= -HALF && resid < HALF);
            end
        end else begin : g_trunc
            localparam logic signed [IW-1:0] STEP = IW'(1) <<< SH_R;
            logic signed [IW-1:0] resid;
            assign quant_o = ext >>> SH_R;
            always_comb begin
                resid = ext - (quant_o <<< SH_R);
                // R2: floor leaves a non-negative remainder below one output step
                assert_floor_R2: assert (resid >= 0 && resid < STEP);
            end
        end
    endgenerate

endmodule

// File: rtl/fxq_limit.sv
module fxq_limit
    import fxq_pkg::*;
#(
    parameter int         W_OUT      = 8,
    parameter bit         OUT_SIGNED = 1'b1,
    parameter int         IW         = 18,
    parameter fxq_omode_e O_MODE     = O_WRAP
) (
    input  logic signed [IW-1:0] quant_i,
    output logic [W_OUT-1:0]     data_o
);
    localparam logic signed [IW-1:0] ONE  = IW'(1);
    localparam logic signed [IW-1:0] MAXV = OUT_SIGNED ? ((ONE <<< (W_OUT - 1)) - ONE)
                                                       : ((ONE <<< W_OUT) - ONE);
    localparam logic signed [IW-1:0] MINV = OUT_SIGNED ? -(ONE <<< (W_OUT - 1))
                                                       : IW'(0);

    generate
        if (O_MODE == O_SAT) begin : g_sat
            always_comb begin
                if (quant_i > MAXV) begin
                    data_o = MAXV[W_OUT-1:0];
                end else if (quant_i < MINV) begin
                    data_o = MINV[W_OUT-1:0];
                end else begin
                    data_o = quant_i[W_OUT-1:0];
                end
            end
        end else begin : g_wrap
            logic unused_high;
            assign unused_high = ^quant_i[IW-1:W_OUT];
            assign data_o      = quant_i[W_OUT-1:0];
        end
    endgenerate

endmodule

// File: rtl/fxq_requant.sv
module fxq_requant
    import fxq_pkg::*;
#(
    parameter int         W_IN       = 16,
    parameter int         I_IN       = 8,
    parameter bit         IN_SIGNED  = 1'b1,
    parameter int         W_OUT      = 8,
    parameter int         I_OUT      = 4,
    parameter bit         OUT_SIGNED = 1'b1,
    parameter fxq_qmode_e Q_MODE     = Q_TRUNC,
    parameter fxq_omode_e O_MODE     = O_WRAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [W_IN-1:0]  data_i,
    output logic             valid_o,
    output logic [W_OUT-1:0] data_o
);
    localparam int F_IN  = W_IN - I_IN;
    localparam int F_OUT = W_OUT - I_OUT;
    localparam int IW    = fxq_work_width(W_IN, I_IN, W_OUT, I_OUT);
    localparam int SH_L  = (F_OUT > F_IN) ? (F_OUT - F_IN) : 0;

    logic signed [IW-1:0] quant;
    logic [W_OUT-1:0]     conv;

    fxq_align #(
        .W_IN      (W_IN),
        .I_IN      (I_IN),
        .IN_SIGNED (IN_SIGNED),
        .F_OUT     (F_OUT),
        .IW        (IW),
        .Q_MODE    (Q_MODE)
    ) u_align (
        .data_i  (data_i),
        .quant_o (quant)
    );

    fxq_limit #(
        .W_OUT      (W_OUT),
        .OUT_SIGNED (OUT_SIGNED),
        .IW         (IW),
        .O_MODE     (O_MODE)
    ) u_limit (
        .quant_i (quant),
        .data_o  (conv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o <= conv;
            end
        end
    end

    // R9: strobe follows input by exactly one clock
    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    // R9: idle cycles leave the output word untouched
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(data_o));

    generate
        if (O_MODE == O_SAT && !OUT_SIGNED && IN_SIGNED) begin : g_chk_neg
            // R7: negative sample into unsigned saturating format gives zero
            assert_neg_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
                (valid_i && data_i[W_IN-1]) |=> (data_o == '0));
        end
        if (O_MODE == O_WRAP && SH_L > 0 && SH_L < W_OUT) begin : g_chk_fill
            // R5: widened fraction bits are zero filled
            assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
                valid_o |-> (data_o[SH_L-1:0] == '0));
        end
    endgenerate

endmodule

// File: tb/fxq_requant_bench.sv
`timescale 1ns/1ps
module fxq_requant_bench;
    import fxq_pkg::*;

    localparam int NK = 13;
    localparam int C_WI [3] = '{10, 10, 6};
    localparam int C_II [3] = '{4, 4, 2};
    localparam int C_SI [3] = '{1, 1, 0};
    localparam int C_WO [3] = '{6, 6, 8};
    localparam int C_IO [3] = '{3, 2, 2};
    localparam int C_SO [3] = '{1, 0, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vin = 1'b0;
    logic [15:0] din = '0;
    logic [NK-1:0] vout;
    logic [15:0] dout [NK];

    logic        exp_v [NK];
    logic [15:0] exp_d [NK];
    string       exp_t [NK];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    generate
        for (genvar c = 0; c < 3; c++) begin : g_cfg
            for (genvar m = 0; m < 4; m++) begin : g_mode
                logic [C_WO[c]-1:0] d;
                fxq_requant #(
                    .W_IN       (C_WI[c]),
                    .I_IN       (C_II[c]),
                    .IN_SIGNED  (C_SI[c] != 0),
                    .W_OUT      (C_WO[c]),
                    .I_OUT      (C_IO[c]),
                    .OUT_SIGNED (C_SO[c] != 0),
                    .Q_MODE     ((m % 2 == 1) ? Q_ROUND : Q_TRUNC),
                    .O_MODE     ((m / 2 == 1) ? O_SAT : O_WRAP)
                ) u_fxq_requant (
                    .clk     (clk),
                    .rst     (rst),
                    .valid_i (vin),
                    .data_i  (din[C_WI[c]-1:0]),
                    .valid_o (vout[c*4+m]),
                    .data_o  (d)
                );
                assign dout[c*4+m] = 16'(d);
            end
        end
    endgenerate

    // R11: all defaults (signed 16.8 -> signed 8.4, truncate, wrap)
    logic [7:0] d_def;
    fxq_requant u_fxq_requant (
        .clk     (clk),
        .rst     (rst),
        .valid_i (vin),
        .data_i  (din),
        .valid_o (vout[12]),
        .data_o  (d_def)
    );
    assign dout[12] = 16'(d_def);

    function automatic longint ref_conv(input longint raw, input int wi, input int ii, input bit si,
                                        input int wo, input int io, input bit so,
                                        input bit rnd, input bit sat, output string tag);
        longint x, v, vt, lo, hi, mask, res;
        int fi, fo, d;
        bit ovf, ovft;
        fi = wi - ii;
        fo = wo - io;
        d  = 0;
        x  = raw & ((64'sd1 <<< wi) - 1);
        if (si && x[wi-1]) x = x - (64'sd1 <<< wi);
        if (fo >= fi) begin
            v  = x <<< (fo - fi);
            vt = v;
        end else begin
            d  = fi - fo;
            vt = x >>> d;
            v  = rnd ? ((x + (64'sd1 <<< (d - 1))) >>> d) : vt;
        end
        lo   = so ? -(64'sd1 <<< (wo - 1)) : 64'sd0;
        hi   = so ? ((64'sd1 <<< (wo - 1)) - 1) : ((64'sd1 <<< wo) - 1);
        mask = (64'sd1 <<< wo) - 1;
        ovf  = (v < lo) || (v > hi);
        ovft = (vt < lo) || (vt > hi);
        if (fo >= fi)               tag = "R5";
        else if (x < 0 && !so)      tag = "R7";
        else if (ovf && !ovft)      tag = "R8";
        else if (ovf)               tag = sat ? "R6" : "R4";
        else if ((vt <<< d) == x)   tag = "R1";
        else                        tag = rnd ? "R3" : "R2";
        if (sat) res = (v > hi) ? hi : ((v < lo) ? lo : v);
        else     res = v;
        return res & mask;
    endfunction

    task automatic compare_all();
        for (int k = 0; k < NK; k++) begin
            checks++;
            if (vout[k] !== exp_v[k]) begin
                errors++;
                $display("FAIL R9 inst %0d valid_o act %0b exp %0b", k, vout[k], exp_v[k]);
            end
            checks++;
            if (dout[k] !== exp_d[k]) begin
                errors++;
                $display("FAIL %s inst %0d data_o act %0h exp %0h", exp_t[k], k, dout[k], exp_d[k]);
            end
        end
    endtask

    task automatic load_expect();
        string  t;
        longint r;
        for (int k = 0; k < NK; k++) begin
            exp_v[k] = vin;
            if (vin) begin
                if (k == 12) begin
                    r = ref_conv(longint'(din), 16, 8, 1'b1, 8, 4, 1'b1, 1'b0, 1'b0, t);
                    t = "R11";
                end else begin
                    r = ref_conv(longint'(din), C_WI[k/4], C_II[k/4], C_SI[k/4] != 0,
                                 C_WO[k/4], C_IO[k/4], C_SO[k/4] != 0,
                                 (k % 4) % 2 == 1, (k % 4) / 2 == 1, t);
                end
                exp_d[k] = 16'(r);
                exp_t[k] = t;
            end else begin
                exp_t[k] = "R9";
            end
        end
    endtask

    task automatic step(input logic v, input logic [15:0] d);
        @(negedge clk);
        compare_all();
        vin = v;
        din = d;
        load_expect();
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int k = 0; k < NK; k++) begin
            exp_v[k] = 1'b0;
            exp_d[k] = '0;
            exp_t[k] = "R10";
        end
        repeat (2) @(negedge clk);
        // R10: reset state
        compare_all();
        @(negedge clk);
        compare_all();
        rst = 1'b0;
        for (int k = 0; k < NK; k++) exp_t[k] = "R9";
        // exhaustive sweep of every 10-bit code, all valid
        for (int i = 0; i < 1024; i++) step(1'b1, 16'(i));
        // idle cycles with changing data: output must hold (R9)
        for (int i = 0; i < 8; i++) step(1'b0, 16'hA5A5 ^ 16'(i * 77));
        // mixed valid pattern with pseudo-random data, wide default input too
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3] | lfsr[7], lfsr);
        end
        // boundary codes on the default instance
        step(1'b1, 16'h7FFF);
        step(1'b1, 16'h8000);
        step(1'b1, 16'hFFFF);
        step(1'b1, 16'h0008);
        step(1'b0, 16'h0000);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog expired act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule